// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Large-Page Entries

This block is an eight-entry, fully associative cache of address translations. Each slot holds a process tag, a virtual page number, a physical frame number, three permission bits, a valid flag and a large-page flag. A lookup presents a process tag, a 32-bit virtual address and an access kind. In the same cycle the block answers with hit, fault and the physical address. Every valid slot is compared in parallel. A large-page slot covers 2 MB (512 pages of 4 KB) and ignores the low nine page-number bits when it compares.

On a miss an external page walker loads the translation through the fill port. The fill takes the lowest free slot if one exists. Otherwise it evicts the least recently used valid slot. Three control inputs remove translations: a full flush, a flush of one process tag, and a single-page invalidate that also removes large-page slots covering that page. The page walk itself is not part of the block.

Top module: `tlb_tagged`

## Requirements
- R1: After reset no slot is valid: every lookup reports hit=0, fault=0 and a physical address of zero.
- R2: A lookup whose process tag and 20-bit page number equal those of a valid 4 KB slot reports hit=1 in the same cycle, with physical address {frame, va[11:0]}.
- R3: A slot only hits for the process tag it was filled with. A lookup that has the same page number but another tag misses.
- R4: A large-page slot matches on page-number bits 19:9 only. Its physical address is {frame[19:9], va[20:0]}.
- R5: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access code 0 is read, 1 is write and 2 is execute; code 3 is never allowed. A hit whose access is not allowed reports hit=1 and fault=1, with a physical address of zero.
- R6: A fill goes into the lowest-numbered free slot. When every slot is valid, it replaces the valid slot used least recently. Both hits (faulting hits included) and fills count as a use.
- R7: A full flush invalidates every slot.
- R8: A flush by process tag invalidates only the slots that carry that tag.
- R9: A page invalidate (tag plus page number) removes every slot of that tag whose page matches, large-page slots included under their masked compare. All other slots are left untouched.
- R10: When a flush and a fill occur in the same cycle, the flush is applied first and the new translation remains valid.
- R11: A lookup that matches no slot reports hit=0, fault=0 and a physical address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request; only a request updates recency |
| lk_pid | input | 8 | Process tag of the lookup |
| lk_va | input | 32 | Virtual address |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | A matching slot was found |
| lk_fault | output | 1 | Matching slot forbids the access |
| lk_pa | output | 32 | Physical address, zero unless hit without fault |
| fl_en | input | 1 | Insert a translation |
| fl_pid | input | 8 | Process tag of the new translation |
| fl_vpn | input | 20 | Virtual page number of the new translation |
| fl_pfn | input | 20 | Physical frame number |
| fl_perm | input | 3 | Permission bits {execute, write, read} |
| fl_big | input | 1 | New translation is a 2 MB page |
| fa_all | input | 1 | Invalidate every slot |
| fp_en | input | 1 | Invalidate slots of one process tag |
| fp_pid | input | 8 | Tag for the flush by tag |
| inv_en | input | 1 | Invalidate one page |
| inv_pid | input | 8 | Tag of the page to invalidate |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The bench targets the large-page edges. An address just past a 2 MB region must miss; a design that masked too many bits would still hit there. An invalidate aimed at a page in the middle of a large page must remove that large slot; a design that compared all page bits would leave a stale translation. For the eviction order, the bench checks that a faulting hit refreshes recency, that a slot freed by invalidate is reused before any eviction, and that a fill issued together with a full flush survives. A design with one of these faults would evict a live hot page or lose the new translation.

// File: rtl/tlb_tagged.sv
module tlb_tagged #(
  parameter int ENTRIES = 8,
  parameter int PID_W   = 8,
  parameter int VA_W    = 32,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int BIG_W   = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_en,
  input  logic [PID_W-1:0]       lk_pid,
  input  logic [VA_W-1:0]        lk_va,
  input  logic [1:0]             lk_acc,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PFN_W+OFF_W-1:0] lk_pa,
  input  logic                   fl_en,
  input  logic [PID_W-1:0]       fl_pid,
  input  logic [VA_W-OFF_W-1:0]  fl_vpn,
  input  logic [PFN_W-1:0]       fl_pfn,
  input  logic [2:0]             fl_perm,
  input  logic                   fl_big,
  input  logic                   fa_all,
  input  logic                   fp_en,
  input  logic [PID_W-1:0]       fp_pid,
  input  logic                   inv_en,
  input  logic [PID_W-1:0]       inv_pid,
  input  logic [VA_W-OFF_W-1:0]  inv_vpn
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int BIG_OFF = OFF_W + BIG_W;

  logic [ENTRIES-1:0] vld, big;
  logic [PID_W-1:0]   pid_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [IDX_W-1:0]   age_q  [ENTRIES];

  function automatic logic page_eq(logic wide, logic [VPN_W-1:0] a, logic [VPN_W-1:0] b);
    return wide ? (a[VPN_W-1:BIG_W] == b[VPN_W-1:BIG_W]) : (a == b);
  endfunction

  wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:OFF_W];

  logic [ENTRIES-1:0] match, kill, live;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = vld[i] && pid_q[i] == lk_pid && page_eq(big[i], vpn_q[i], lk_vpn);
      kill[i]  = fa_all
              || (fp_en && pid_q[i] == fp_pid)
              || (inv_en && pid_q[i] == inv_pid && page_eq(big[i], vpn_q[i], inv_vpn));
    end
  end
  assign live = vld & ~kill;

  logic [IDX_W-1:0] hit_idx, victim;
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    victim = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (age_q[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!live[i]) victim = IDX_W'(i);
  end

  wire [PFN_W-1:0] sel_pfn  = pfn_q[hit_idx];
  wire [2:0]       sel_perm = perm_q[hit_idx];
  wire             sel_big  = big[hit_idx];

  logic allowed;
  always_comb begin
    case (lk_acc)
      2'd0:    allowed = sel_perm[0];
      2'd1:    allowed = sel_perm[1];
      2'd2:    allowed = sel_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  wire [PA_W-1:0] pa_raw = sel_big ? {sel_pfn[PFN_W-1:BIG_W], lk_va[BIG_OFF-1:0]}
                                   : {sel_pfn, lk_va[OFF_W-1:0]};

  assign lk_hit   = lk_en && (|match);
  assign lk_fault = lk_hit && !allowed;
  assign lk_pa    = (lk_hit && allowed) ? pa_raw : '0;

  wire              touch     = fl_en || lk_hit;
  wire [IDX_W-1:0]  touch_idx = fl_en ? victim : hit_idx;
  wire [IDX_W-1:0]  touch_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      vld <= live;
      if (fl_en) begin
        vld[victim]    <= 1'b1;
        big[victim]    <= fl_big;
        pid_q[victim]  <= fl_pid;
        vpn_q[victim]  <= fl_vpn;
        pfn_q[victim]  <= fl_pfn;
        perm_q[victim] <= fl_perm;
      end
      if (touch) begin
        for (int j = 0; j < ENTRIES; j++)
          if (age_q[j] < touch_age) age_q[j] <= age_q[j] + 1'b1;
        age_q[touch_idx] <= '0;
      end
    end
  end
endmodule

// File: rtl/tlb_tagged_chk.sv
module tlb_tagged_chk #(
  parameter int ENTRIES = 8,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_en,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic [PA_W-1:0]    lk_pa,
  input logic               fl_en,
  input logic               fa_all,
  input logic [ENTRIES-1:0] vld
);
  p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_en);

  p_hit_needs_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> vld != '0);

  p_fault_is_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_fault_no_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_pa == '0);

  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && !lk_fault));

  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en |=> vld != '0);

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_all && !fl_en) |=> vld == '0);

  p_flush_then_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_all && fl_en) |=> $countones(vld) == 1);
endmodule

bind tlb_tagged tlb_tagged_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_hit(lk_hit), .lk_fault(lk_fault),
  .lk_pa(lk_pa), .fl_en(fl_en), .fa_all(fa_all), .vld(vld)
);

// File: tb/tlb_tagged_bench.sv
module tlb_tagged_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_en = 0;
  logic [7:0]  lk_pid = 0;
  logic [31:0] lk_va = 0;
  logic [1:0]  lk_acc = 0;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_pa;
  logic        fl_en = 0;
  logic [7:0]  fl_pid = 0;
  logic [19:0] fl_vpn = 0;
  logic [19:0] fl_pfn = 0;
  logic [2:0]  fl_perm = 0;
  logic        fl_big = 0;
  logic        fa_all = 0;
  logic        fp_en = 0;
  logic [7:0]  fp_pid = 0;
  logic        inv_en = 0;
  logic [7:0]  inv_pid = 0;
  logic [19:0] inv_vpn = 0;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  tlb_tagged u_tlb_tagged (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_pid(lk_pid), .lk_va(lk_va),
    .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pa(lk_pa),
    .fl_en(fl_en), .fl_pid(fl_pid), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
    .fl_perm(fl_perm), .fl_big(fl_big), .fa_all(fa_all), .fp_en(fp_en),
    .fp_pid(fp_pid), .inv_en(inv_en), .inv_pid(inv_pid), .inv_vpn(inv_vpn)
  );

  typedef struct packed {
    logic [7:0]  pid;
    logic [31:0] va;
    logic [1:0]  acc;
    logic        hit;
    logic        fault;
    logic [31:0] pa;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{8'd1, 32'h0001_0345, 2'd0, 1'b1, 1'b0, 32'h00AB_C345},  // R2
    '{8'd1, 32'h0001_0FFF, 2'd1, 1'b1, 1'b0, 32'h00AB_CFFF},  // R2 write allowed
    '{8'd2, 32'h0001_0123, 2'd0, 1'b1, 1'b0, 32'h00DE_F123},  // R3 other tag, own slot
    '{8'd3, 32'h0001_0000, 2'd0, 1'b0, 1'b0, 32'h0},          // R3 unknown tag
    '{8'd1, 32'h0001_0000, 2'd2, 1'b1, 1'b1, 32'h0},          // R5 exec denied
    '{8'd2, 32'h0001_0000, 2'd1, 1'b1, 1'b1, 32'h0},          // R5 write denied
    '{8'd1, 32'h0001_0000, 2'd3, 1'b1, 1'b1, 32'h0},          // R5 reserved code
    '{8'd1, 32'h005F_FABC, 2'd0, 1'b1, 1'b0, 32'h123F_FABC},  // R4 top of large page
    '{8'd1, 32'h0040_0000, 2'd2, 1'b1, 1'b0, 32'h1220_0000},  // R4 base of large page
    '{8'd1, 32'h0060_0000, 2'd0, 1'b0, 1'b0, 32'h0},          // R4 just past region
    '{8'd2, 32'h0040_0000, 2'd0, 1'b0, 1'b0, 32'h0},          // R3 large page other tag
    '{8'd1, 32'h0001_1000, 2'd0, 1'b0, 1'b0, 32'h0}           // R11 neighbour page
  };

  task automatic idle();
    lk_en = 0; fl_en = 0; fa_all = 0; fp_en = 0; inv_en = 0;
  endtask

  task automatic look(input logic [7:0] pid, input logic [31:0] va, input logic [1:0] acc,
                      input logic eh, input logic ef, input logic [31:0] epa, input string req);
    @(negedge clk);
    idle();
    lk_pid = pid; lk_va = va; lk_acc = acc; lk_en = 1;
    #5;
    vectors++;
    if (lk_hit !== eh || lk_fault !== ef || lk_pa !== epa) begin
      miscompares++;
      $display("FAIL %s: hit/fault/pa = %b/%b/%h, expected %b/%b/%h",
               req, lk_hit, lk_fault, lk_pa, eh, ef, epa);
    end
  endtask

  task automatic fill(input logic [7:0] pid, input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic [2:0] perm, input logic wide, input logic flush);
    @(negedge clk);
    idle();
    fl_pid = pid; fl_vpn = vpn; fl_pfn = pfn; fl_perm = perm; fl_big = wide;
    fl_en = 1; fa_all = flush;
  endtask

  task automatic flush_all();
    @(negedge clk); idle(); fa_all = 1;
  endtask

  task automatic flush_pid(input logic [7:0] pid);
    @(negedge clk); idle(); fp_en = 1; fp_pid = pid;
  endtask

  task automatic inval(input logic [7:0] pid, input logic [19:0] vpn);
    @(negedge clk); idle(); inv_en = 1; inv_pid = pid; inv_vpn = vpn;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    do_reset();
    look(8'd1, 32'h0001_0000, 2'd0, 0, 0, 32'h0, "R1 empty after reset");

    fill(8'd1, 20'h00010, 20'h00ABC, 3'b011, 0, 0);
    fill(8'd2, 20'h00010, 20'h00DEF, 3'b101, 0, 0);
    fill(8'd1, 20'h00400, 20'h12200, 3'b111, 1, 0);
    for (int i = 0; i < 12; i++)
      look(TABLE[i].pid, TABLE[i].va, TABLE[i].acc, TABLE[i].hit, TABLE[i].fault,
           TABLE[i].pa, "R2/R3/R4/R5/R11 table");

    inval(8'd1, 20'h00500);
    look(8'd1, 32'h0040_0000, 2'd0, 0, 0, 32'h0, "R9 large page removed");
    look(8'd1, 32'h0001_0000, 2'd0, 1, 0, 32'h00AB_C000, "R9 other page kept");
    look(8'd2, 32'h0001_0000, 2'd0, 1, 0, 32'h00DE_F000, "R9 other tag kept");

    flush_pid(8'd2);
    look(8'd2, 32'h0001_0000, 2'd0, 0, 0, 32'h0, "R8 tag flushed");
    look(8'd1, 32'h0001_0000, 2'd0, 1, 0, 32'h00AB_C000, "R8 other tag kept");

    flush_all();
    look(8'd1, 32'h0001_0000, 2'd0, 0, 0, 32'h0, "R7 full flush");

    fill(8'd1, 20'h00010, 20'h00ABC, 3'b011, 0, 0);
    fill(8'd5, 20'h00020, 20'h00077, 3'b001, 0, 1);
    look(8'd5, 32'h0002_0000, 2'd0, 1, 0, 32'h0007_7000, "R10 fill survives flush");
    look(8'd1, 32'h0001_0000, 2'd0, 0, 0, 32'h0, "R10 old slot flushed");

    do_reset();
    look(8'd5, 32'h0002_0000, 2'd0, 0, 0, 32'h0, "R1 reset clears slots");
    for (int i = 0; i < 8; i++)
      fill(8'd9, 20'h00100 + 20'(i), 20'h00200 + 20'(i), 3'b001, 0, 0);
    look(8'd9, 32'h0010_0000, 2'd0, 1, 0, 32'h0020_0000, "R6 refresh oldest");
    fill(8'd9, 20'h00180, 20'h00280, 3'b001, 0, 0);
    look(8'd9, 32'h0010_1000, 2'd0, 0, 0, 32'h0, "R6 LRU evicted");
    look(8'd9, 32'h0010_0000, 2'd0, 1, 0, 32'h0020_0000, "R6 refreshed kept");
    look(8'd9, 32'h0018_0000, 2'd0, 1, 0, 32'h0028_0000, "R6 new slot");
    look(8'd9, 32'h0010_2000, 2'd1, 1, 1, 32'h0, "R6 faulting hit");
    fill(8'd9, 20'h00181, 20'h00281, 3'b001, 0, 0);
    look(8'd9, 32'h0010_3000, 2'd0, 0, 0, 32'h0, "R6 fault counted as use");
    look(8'd9, 32'h0010_2000, 2'd0, 1, 0, 32'h0020_2000, "R6 faulted slot kept");
    inval(8'd9, 20'h00105);
    fill(8'd9, 20'h00182, 20'h00282, 3'b001, 0, 0);
    look(8'd9, 32'h0010_4000, 2'd0, 1, 0, 32'h0020_4000, "R6 free slot used first");
    look(8'd9, 32'h0018_2000, 2'd0, 1, 0, 32'h0028_2000, "R6 fill into free slot");
    look(8'd9, 32'h0010_5000, 2'd0, 0, 0, 32'h0, "R9 single page gone");

    @(negedge clk);
    idle();
    summary();
  end
endmodule